// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block services translation misses by fetching page table entries from memory on its own. Given a 32-bit virtual address, a flag saying whether the access was an instruction fetch, and the frame number of the top-level directory, it reads the directory entry and, when needed, the second-level leaf entry. It then either produces a fill record for the translation cache or reports a page fault. Pages are 8 KB. The upper 8 bits of the virtual address select one of 256 directory slots. The next 11 bits select one of 2048 leaf slots inside a table that always fills exactly one page. A present directory entry that has its last flag set stops the walk at once and maps a 16 MB huge page.

The same engine also handles write-back. When the translation cache evicts an entry, the block walks to the entry that backs it. It rewrites that entry with the accessed and dirty bits merged in and leaves every other bit as it was. The block runs one operation at a time and issues single-word transfers on a request/acknowledge memory port.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and afterwards until a request is accepted, the block drives mem_req, fill_done, fill_fault, wb_done and busy low. A request offered while the block is idle is accepted in that cycle.
- R2: The first read of every operation goes to dir_base·8192 + vaddr[31:24]·4.
- R3: When the directory entry is present (bit 10 = 1) and not last (bit 11 = 0), a second read goes to {entry[31:13], vaddr[23:13], 2'b00}. A present leaf then gives fill_frame = leaf[31:13], fill_prot = leaf[2:0] (bit 2 execute, bit 1 write, bit 0 user) and fill_huge = 0.
- R4: A directory entry with bits 10 and 11 both set ends the walk after a single read. It gives fill_huge = 1, fill_frame = {entry[31:24], vaddr[23:13]} and fill_prot = entry[2:0].
- R5: An entry with bit 10 clear at either level makes the block raise fill_fault. No further memory access follows, and the other bits of that entry are ignored.
- R6: A walk for an instruction fetch faults when the final entry has its execute bit (bit 2) clear. A data walk on the same entry completes normally.
- R7: fill_done and fill_fault are never high together. Each completion is exactly one cycle long and matches exactly one accepted miss.
- R8: Once mem_req is raised, it stays high with mem_addr, mem_we and mem_wdata unchanged until the cycle in which mem_ack is seen.
- R9: A write-back walks the same path as a miss (directory entry when it is huge, leaf otherwise). It then performs one write of that entry with bit 4 set by wb_accessed and bit 5 set by wb_dirty (ORed in), keeps all other bits, and pulses wb_done.
- R10: A write-back that finds a non-present entry at either level performs no write and still pulses wb_done.
- R11: If a miss and a write-back are offered in the same idle cycle, the write-back is accepted first. The miss is accepted only after wb_done.
- R12: While busy is high, neither request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 19 | Frame number of the top-level directory |
| miss_valid | input | 1 | Miss request, held until accepted |
| miss_vaddr | input | 32 | Virtual address that missed |
| miss_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| miss_accept | output | 1 | Miss taken this cycle |
| wb_valid | input | 1 | Write-back request, held until accepted |
| wb_vaddr | input | 32 | Virtual address of the evicted translation |
| wb_accessed | input | 1 | Accessed bit to merge |
| wb_dirty | input | 1 | Dirty bit to merge |
| wb_accept | output | 1 | Write-back taken this cycle |
| busy | output | 1 | An operation is in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed (read data valid) |
| mem_rdata | input | 32 | Read data |
| fill_done | output | 1 | Fill record valid for one cycle |
| fill_fault | output | 1 | Page fault for one cycle |
| fill_frame | output | 19 | Physical frame of the 8 KB page |
| fill_prot | output | 3 | Execute, write, user |
| fill_huge | output | 1 | Translation comes from a 16 MB page |
| wb_done | output | 1 | Write-back finished, one cycle |

## Verification
A miss and an eviction write-back can both ask for the walker in the same idle cycle. The bench provokes this by raising both requests on one falling edge and keeping the miss held. It then judges three things. The write-back must be taken alone in that cycle. The miss must not be taken until after wb_done has been seen. The written entry and the later fill must both match values the bench computes from its own memory image.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
   // entry flag positions inside a 32-bit table word
   localparam int PTE_USER    = 0;
   localparam int PTE_WRITE   = 1;
   localparam int PTE_EXEC    = 2;
   localparam int PTE_ACC     = 4;
   localparam int PTE_DIRTY   = 5;
   localparam int PTE_PRESENT = 10;
   localparam int PTE_LAST    = 11;
   localparam int PROT_W      = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ_L1,
      ST_READ_L2,
      ST_WRITE,
      ST_DONE,
      ST_FAULT
   } walk_state_t;
endpackage

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen #(
   parameter int VA_W        = 32,
   parameter int PAGE_BITS   = 13,
   parameter int DIR_BITS    = 8,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [VA_W-PAGE_BITS-1:0] base_frame,
   input  logic [VA_W-PAGE_BITS-1:0] table_frame,
   input  logic [VA_W-PAGE_BITS-1:0] vpn,
   output logic [VA_W-1:0]           dir_addr,
   output logic [VA_W-1:0]           leaf_addr
);
   localparam int VPN_W     = VA_W - PAGE_BITS;
   localparam int TBL_BITS  = VPN_W - DIR_BITS;
   localparam int IDX_SHIFT = $clog2(ENTRY_BYTES);

   logic [DIR_BITS-1:0] dir_idx;
   logic [TBL_BITS-1:0] tbl_idx;

   assign dir_idx = vpn[VPN_W-1 -: DIR_BITS];
   assign tbl_idx = vpn[TBL_BITS-1:0];

   // tables are page aligned, so the base occupies the frame field
   assign dir_addr  = {base_frame, {PAGE_BITS{1'b0}}}
                    + VA_W'({dir_idx, {IDX_SHIFT{1'b0}}});
   assign leaf_addr = {table_frame, {PAGE_BITS{1'b0}}}
                    + VA_W'({tbl_idx, {IDX_SHIFT{1'b0}}});
endmodule

// File: rtl/ptw_entry_decode.sv
`timescale 1ns/1ps
module ptw_entry_decode
   import ptw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 13
) (
   input  logic [VA_W-1:0]           entry,
   input  logic                      set_acc,
   input  logic                      set_dirty,
   output logic [VA_W-PAGE_BITS-1:0] frame,
   output logic                      present,
   output logic                      last,
   output logic [PROT_W-1:0]         prot,
   output logic [VA_W-1:0]           merged
);
   assign frame   = entry[VA_W-1:PAGE_BITS];
   assign present = entry[PTE_PRESENT];
   assign last    = entry[PTE_LAST];
   assign prot    = {entry[PTE_EXEC], entry[PTE_WRITE], entry[PTE_USER]};

   always_comb begin
      merged            = entry;
      merged[PTE_ACC]   = entry[PTE_ACC]   | set_acc;
      merged[PTE_DIRTY] = entry[PTE_DIRTY] | set_dirty;
   end
endmodule

// File: rtl/ptw_perm_check.sv
`timescale 1ns/1ps
module ptw_perm_check #(
   parameter bit FETCH_NEEDS_EXEC = 1'b1
) (
   input  logic present,
   input  logic fetch,
   input  logic exec,
   output logic leaf_ok
);
   generate
      if (FETCH_NEEDS_EXEC) begin : g_exec_rule
         assign leaf_ok = present & (~fetch | exec);
      end else begin : g_present_only
         logic unused_bits;
         assign unused_bits = fetch ^ exec;
         assign leaf_ok     = present;
      end
   endgenerate
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W             = 32,
   parameter int PAGE_BITS        = 13,
   parameter int DIR_BITS         = 8,
   parameter int ENTRY_BYTES      = 4,
   parameter bit FETCH_NEEDS_EXEC = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [VA_W-PAGE_BITS-1:0] dir_base,
   input  logic                      miss_valid,
   input  logic [VA_W-1:0]           miss_vaddr,
   input  logic                      miss_fetch,
   output logic                      miss_accept,
   input  logic                      wb_valid,
   input  logic [VA_W-1:0]           wb_vaddr,
   input  logic                      wb_accessed,
   input  logic                      wb_dirty,
   output logic                      wb_accept,
   output logic                      busy,
   output logic                      mem_req,
   output logic                      mem_we,
   output logic [VA_W-1:0]           mem_addr,
   output logic [VA_W-1:0]           mem_wdata,
   input  logic                      mem_ack,
   input  logic [VA_W-1:0]           mem_rdata,
   output logic                      fill_done,
   output logic                      fill_fault,
   output logic [VA_W-PAGE_BITS-1:0] fill_frame,
   output logic [PROT_W-1:0]         fill_prot,
   output logic                      fill_huge,
   output logic                      wb_done
);
   localparam int FRAME_W  = VA_W - PAGE_BITS;
   localparam int TBL_BITS = FRAME_W - DIR_BITS;

   generate
      if (PAGE_BITS <= PTE_LAST) begin : g_bad_page
         $error("PAGE_BITS leaves no room for the entry flags");
      end
      if (TBL_BITS + $clog2(ENTRY_BYTES) > PAGE_BITS) begin : g_bad_split
         $error("second-level table does not fit in one page");
      end
      if (ENTRY_BYTES < 2) begin : g_bad_entry
         $error("ENTRY_BYTES must be at least 2");
      end
   endgenerate

   walk_state_t         state;
   logic                op_wb;
   logic                fetch_q, acc_q, dirty_q, huge_q;
   logic [FRAME_W-1:0]  vpn_q, base_q, tbl_q, frame_q;
   logic [PROT_W-1:0]   prot_q;
   logic [VA_W-1:0]     wr_addr_q, wdata_q;

   logic [VA_W-1:0]     dir_addr, leaf_addr;
   logic [FRAME_W-1:0]  d_frame;
   logic                d_present, d_last;
   logic [PROT_W-1:0]   d_prot;
   logic [VA_W-1:0]     d_merged;
   logic                leaf_ok;

   ptw_addr_gen #(
      .VA_W(VA_W), .PAGE_BITS(PAGE_BITS),
      .DIR_BITS(DIR_BITS), .ENTRY_BYTES(ENTRY_BYTES)
   ) u_addr (
      .base_frame (base_q),
      .table_frame(tbl_q),
      .vpn        (vpn_q),
      .dir_addr   (dir_addr),
      .leaf_addr  (leaf_addr)
   );

   ptw_entry_decode #(
      .VA_W(VA_W), .PAGE_BITS(PAGE_BITS)
   ) u_dec (
      .entry    (mem_rdata),
      .set_acc  (acc_q),
      .set_dirty(dirty_q),
      .frame    (d_frame),
      .present  (d_present),
      .last     (d_last),
      .prot     (d_prot),
      .merged   (d_merged)
   );

   ptw_perm_check #(
      .FETCH_NEEDS_EXEC(FETCH_NEEDS_EXEC)
   ) u_perm (
      .present(d_present),
      .fetch  (fetch_q),
      .exec   (d_prot[2]),
      .leaf_ok(leaf_ok)
   );

   // write-back has priority so memory is current before a new walk
   assign wb_accept   = (state == ST_IDLE) & wb_valid;
   assign miss_accept = (state == ST_IDLE) & miss_valid & ~wb_valid;
   assign busy        = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         op_wb     <= 1'b0;
         fetch_q   <= 1'b0;
         acc_q     <= 1'b0;
         dirty_q   <= 1'b0;
         huge_q    <= 1'b0;
         vpn_q     <= '0;
         base_q    <= '0;
         tbl_q     <= '0;
         frame_q   <= '0;
         prot_q    <= '0;
         wr_addr_q <= '0;
         wdata_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (wb_valid) begin
                  op_wb   <= 1'b1;
                  vpn_q   <= wb_vaddr[VA_W-1:PAGE_BITS];
                  acc_q   <= wb_accessed;
                  dirty_q <= wb_dirty;
                  fetch_q <= 1'b0;
                  base_q  <= dir_base;
                  state   <= ST_READ_L1;
               end else if (miss_valid) begin
                  op_wb   <= 1'b0;
                  vpn_q   <= miss_vaddr[VA_W-1:PAGE_BITS];
                  fetch_q <= miss_fetch;
                  acc_q   <= 1'b0;
                  dirty_q <= 1'b0;
                  base_q  <= dir_base;
                  state   <= ST_READ_L1;
               end
            end
            ST_READ_L1: begin
               if (mem_ack) begin
                  tbl_q <= d_frame;
                  if (!d_present) begin
                     state <= op_wb ? ST_DONE : ST_FAULT;
                  end else if (d_last) begin
                     if (op_wb) begin
                        wr_addr_q <= dir_addr;
                        wdata_q   <= d_merged;
                        state     <= ST_WRITE;
                     end else begin
                        huge_q  <= 1'b1;
                        frame_q <= {d_frame[FRAME_W-1 -: DIR_BITS],
                                    vpn_q[TBL_BITS-1:0]};
                        prot_q  <= d_prot;
                        state   <= leaf_ok ? ST_DONE : ST_FAULT;
                     end
                  end else begin
                     state <= ST_READ_L2;
                  end
               end
            end
            ST_READ_L2: begin
               if (mem_ack) begin
                  if (!d_present) begin
                     state <= op_wb ? ST_DONE : ST_FAULT;
                  end else if (op_wb) begin
                     wr_addr_q <= leaf_addr;
                     wdata_q   <= d_merged;
                     state     <= ST_WRITE;
                  end else begin
                     huge_q  <= 1'b0;
                     frame_q <= d_frame;
                     prot_q  <= d_prot;
                     state   <= leaf_ok ? ST_DONE : ST_FAULT;
                  end
               end
            end
            ST_WRITE: begin
               if (mem_ack) state <= ST_DONE;
            end
            ST_DONE:  state <= ST_IDLE;
            ST_FAULT: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state)
         ST_READ_L1: begin
            mem_req  = 1'b1;
            mem_addr = dir_addr;
         end
         ST_READ_L2: begin
            mem_req  = 1'b1;
            mem_addr = leaf_addr;
         end
         ST_WRITE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = wr_addr_q;
            mem_wdata = wdata_q;
         end
         default: ;
      endcase
   end

   assign fill_done  = (state == ST_DONE) & ~op_wb;
   assign wb_done    = (state == ST_DONE) & op_wb;
   assign fill_fault = (state == ST_FAULT);
   assign fill_frame = frame_q;
   assign fill_prot  = prot_q;
   assign fill_huge  = fill_done & huge_q;
endmodule

// File: rtl/ptw_walker_checker.sv
`timescale 1ns/1ps
module ptw_walker_checker #(
   parameter int VA_W   = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            miss_valid,
   input logic            miss_accept,
   input logic            wb_valid,
   input logic            wb_accept,
   input logic            busy,
   input logic            mem_req,
   input logic            mem_we,
   input logic [VA_W-1:0] mem_addr,
   input logic [VA_W-1:0] mem_wdata,
   input logic            mem_ack,
   input logic            fill_done,
   input logic            fill_fault,
   input logic            fill_huge,
   input logic            wb_done
);
   assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !fill_done && !fill_fault && !wb_done);

   assert_huge_with_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_huge |-> fill_done);

   assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_done && fill_fault));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> !fill_done);

   assert_fault_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_fault |=> !fill_fault);

   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr)
                              && $stable(mem_we) && $stable(mem_wdata));

   assert_wb_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid && miss_valid && wb_accept |-> !miss_accept);

   assert_accept_starts_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_accept || wb_accept) |=> busy);
endmodule

bind ptw_walker ptw_walker_checker #(.VA_W(VA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .miss_valid(miss_valid), .miss_accept(miss_accept),
   .wb_valid(wb_valid), .wb_accept(wb_accept), .busy(busy),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_ack(mem_ack),
   .fill_done(fill_done), .fill_fault(fill_fault),
   .fill_huge(fill_huge), .wb_done(wb_done)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [18:0] dir_base = 19'h00010;
   logic        miss_valid = 0, miss_fetch = 0;
   logic [31:0] miss_vaddr = '0;
   logic        wb_valid = 0, wb_accessed = 0, wb_dirty = 0;
   logic [31:0] wb_vaddr = '0;
   logic        miss_accept, wb_accept, busy;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        fill_done, fill_fault, fill_huge, wb_done;
   logic [18:0] fill_frame;
   logic [2:0]  fill_prot;

   always #2 clk = ~clk;   // 4 ns period

   ptw_walker uut (
      .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
      .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_fetch(miss_fetch),
      .miss_accept(miss_accept),
      .wb_valid(wb_valid), .wb_vaddr(wb_vaddr), .wb_accessed(wb_accessed),
      .wb_dirty(wb_dirty), .wb_accept(wb_accept), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .fill_done(fill_done), .fill_fault(fill_fault), .fill_frame(fill_frame),
      .fill_prot(fill_prot), .fill_huge(fill_huge), .wb_done(wb_done)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   task automatic check(bit ok, string req, string what,
                        logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [31:0] mem [logic [31:0]];
   int          lat = 0;
   int          wait_cnt = 0;
   int          rd_count = 0, wr_count = 0;
   logic [31:0] rd_a1 = '0, rd_a2 = '0;
   int          hold_err = 0;
   logic        prev_pend = 0;
   logic [31:0] prev_addr = '0;
   logic        prev_we = 0;

   function automatic logic [31:0] rd(logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (!rst_n) begin
         wait_cnt  = 0;
         prev_pend = 0;
      end else begin
         if (prev_pend && (!mem_req || mem_addr != prev_addr || mem_we != prev_we))
            hold_err++;
         prev_pend = mem_req && !mem_ack;
         prev_addr = mem_addr;
         prev_we   = mem_we;
         if (miss_accept || wb_accept) begin
            rd_count = 0; wr_count = 0; rd_a1 = '0; rd_a2 = '0;
         end
         if (mem_req && !mem_ack) begin
            if (wait_cnt >= lat) begin
               wait_cnt = 0;
               mem_ack <= 1'b1;
               if (mem_we) begin
                  mem[mem_addr] = mem_wdata;
                  wr_count++;
               end else begin
                  mem_rdata <= rd(mem_addr);
                  if (rd_count == 0) rd_a1 = mem_addr; else rd_a2 = mem_addr;
                  rd_count++;
               end
            end else begin
               wait_cnt++;
            end
         end
      end
   end

   // ---------------- reference model and scoreboard ----------------
   typedef struct packed {
      logic [1:0]  kind;     // 0 fill, 1 fault, 2 write-back
      logic [18:0] frame;
      logic [2:0]  prot;
      logic        huge;
      logic [31:0] a1;
      logic [31:0] a2;
      logic [1:0]  nreads;
      logic [31:0] wb_addr;
      logic [31:0] wb_val;
      logic        nwrites;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   bit    wb_seen = 0;
   int    busy_accepts = 0;

   function automatic logic [31:0] mk_pte(logic [18:0] fr, bit p, bit l, bit x, bit w, bit u);
      logic [31:0] e;
      e = {fr, 13'h0};
      e[10] = p; e[11] = l; e[2] = x; e[1] = w; e[0] = u;
      return e;
   endfunction

   function automatic exp_t model(logic [31:0] va, bit fetch, bit is_wb, bit acc, bit dty);
      exp_t r;
      logic [31:0] e1, e2, leaf, bits;
      r = '0;
      bits = 32'h0; bits[4] = acc; bits[5] = dty;
      r.a1 = {dir_base, 13'h0} + {22'h0, va[31:24], 2'b00};
      e1 = rd(r.a1);
      r.nreads = 2'd1;
      if (!e1[10]) begin
         r.kind = is_wb ? 2'd2 : 2'd1;
         return r;
      end
      if (e1[11]) begin
         leaf = e1;
         r.huge = 1'b1;
         r.frame = {e1[31:24], va[23:13]};
         r.wb_addr = r.a1;
      end else begin
         r.a2 = {e1[31:13], va[23:13], 2'b00};
         e2 = rd(r.a2);
         r.nreads = 2'd2;
         if (!e2[10]) begin
            r.kind = is_wb ? 2'd2 : 2'd1;
            return r;
         end
         leaf = e2;
         r.frame = e2[31:13];
         r.wb_addr = r.a2;
      end
      r.prot = leaf[2:0];
      if (is_wb) begin
         r.kind = 2'd2; r.nwrites = 1'b1; r.wb_val = leaf | bits;
      end else begin
         r.kind = (fetch && !leaf[2]) ? 2'd1 : 2'd0;
      end
      return r;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && (miss_accept || wb_accept)) busy_accepts++;
         if (fill_done || fill_fault || wb_done) begin
            logic [1:0] got;
            got = fill_done ? 2'd0 : (fill_fault ? 2'd1 : 2'd2);
            if (wb_done) wb_seen = 1;
            if (exp_q.size() == 0) begin
               check(0, "R7", "completion with nothing pending", got, 0);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(got == e.kind, t, "completion kind", got, e.kind);
               check(rd_count == e.nreads, t, "read count", rd_count, e.nreads);
               check(rd_a1 == e.a1, {t, "/R2"}, "directory read address", rd_a1, e.a1);
               if (e.nreads == 2)
                  check(rd_a2 == e.a2, {t, "/R3"}, "leaf read address", rd_a2, e.a2);
               if (got == 2'd0 && e.kind == 2'd0) begin
                  check(fill_frame == e.frame, t, "frame", fill_frame, e.frame);
                  check(fill_prot == e.prot, t, "prot", fill_prot, e.prot);
                  check(fill_huge == e.huge, t, "huge flag", fill_huge, e.huge);
               end
               if (e.kind == 2'd2) begin
                  check(wr_count == e.nwrites, t, "write count", wr_count, e.nwrites);
                  if (e.nwrites)
                     check(rd(e.wb_addr) == e.wb_val, t, "written entry",
                           rd(e.wb_addr), e.wb_val);
               end
            end
         end
      end
   end

   // ---------------- driver ----------------
   task automatic wait_idle();
      do @(negedge clk); while (busy || exp_q.size() != 0);
   endtask

   task automatic run_miss(logic [31:0] va, bit fetch, string tag);
      exp_q.push_back(model(va, fetch, 1'b0, 1'b0, 1'b0));
      tag_q.push_back(tag);
      miss_vaddr = va; miss_fetch = fetch; miss_valid = 1'b1;
      #1;
      while (!miss_accept) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      miss_valid = 1'b0;
      wait_idle();
   endtask

   task automatic run_wb(logic [31:0] va, bit acc, bit dty, string tag);
      exp_q.push_back(model(va, 1'b0, 1'b1, acc, dty));
      tag_q.push_back(tag);
      wb_vaddr = va; wb_accessed = acc; wb_dirty = dty; wb_valid = 1'b1;
      #1;
      while (!wb_accept) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      wb_valid = 1'b0;
      wait_idle();
   endtask

   localparam logic [31:0] DIR = 32'h0002_0000;
   localparam logic [31:0] TBL = 32'h0020_0000;

   function automatic logic [31:0] va_of(logic [7:0] d, logic [10:0] t, logic [12:0] o);
      return {d, t, o};
   endfunction

   initial begin
      // directory: slot 1 -> table, slot C0/C1 huge, slot 2 absent
      mem[DIR + 32'h4]        = mk_pte(19'h00100, 1, 0, 0, 0, 0);
      mem[DIR + 32'h3 * 4]    = mk_pte(19'h7FFFF, 0, 1, 1, 1, 1); // not present, junk bits
      mem[DIR + 32'hC0 * 4]   = mk_pte({8'hA5, 11'h0}, 1, 1, 1, 1, 0);
      mem[DIR + 32'hC1 * 4]   = mk_pte({8'h3C, 11'h0}, 1, 1, 0, 1, 1);
      mem[TBL + 32'h5 * 4]    = mk_pte(19'h45678, 1, 0, 1, 1, 0);
      mem[TBL + 32'h6 * 4]    = mk_pte(19'h11111, 0, 0, 1, 1, 1);
      mem[TBL + 32'h7 * 4]    = mk_pte(19'h2ABCD, 1, 0, 0, 1, 1);
      mem[TBL + 32'h7FF * 4]  = mk_pte(19'h00001, 1, 0, 1, 0, 1) | 32'h10;

      repeat (3) @(negedge clk);
      // R1: quiet during reset
      check(!mem_req && !fill_done && !fill_fault && !wb_done && !busy,
            "R1", "outputs in reset", {mem_req, fill_done, fill_fault, wb_done, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!mem_req && !busy, "R1", "outputs after reset", {mem_req, busy}, 0);

      lat = 0;
      run_miss(va_of(8'h01, 11'h005, 13'h123), 0, "R3");       // data walk, two levels
      run_miss(va_of(8'h01, 11'h005, 13'h000), 1, "R6");       // fetch, executable
      run_miss(va_of(8'h01, 11'h007, 13'h010), 1, "R6");       // fetch, not executable -> fault
      lat = 2;
      run_miss(va_of(8'h01, 11'h007, 13'h010), 0, "R6");       // data, same leaf -> fill
      run_miss(va_of(8'h01, 11'h006, 13'h000), 0, "R5");       // leaf not present
      run_miss(va_of(8'h03, 11'h006, 13'h000), 0, "R5");       // dir not present, junk ignored
      run_miss(va_of(8'h02, 11'h000, 13'h000), 1, "R5");       // dir absent
      lat = 1;
      run_miss(va_of(8'hC0, 11'h3A5, 13'h1FFF), 0, "R4");      // huge data
      run_miss(va_of(8'hC0, 11'h7FF, 13'h0), 1, "R4");         // huge fetch, exec ok
      run_miss(va_of(8'hC1, 11'h001, 13'h0), 1, "R4");         // huge fetch, not exec -> fault
      run_miss(va_of(8'h01, 11'h7FF, 13'h0), 0, "R3");         // last table slot

      run_wb(va_of(8'h01, 11'h005, 13'h0), 1, 1, "R9");        // leaf write-back
      run_wb(va_of(8'h01, 11'h7FF, 13'h0), 0, 1, "R9");        // accessed already set
      lat = 0;
      run_wb(va_of(8'hC0, 11'h123, 13'h0), 1, 0, "R9");        // huge: directory entry
      run_wb(va_of(8'h01, 11'h006, 13'h0), 1, 1, "R10");       // leaf absent
      run_wb(va_of(8'h02, 11'h006, 13'h0), 1, 1, "R10");       // dir absent
      check(!mem.exists(TBL + 32'h6 * 4) || rd(TBL + 32'h6 * 4) == mk_pte(19'h11111, 0, 0, 1, 1, 1),
            "R10", "absent leaf untouched", rd(TBL + 32'h6 * 4), mk_pte(19'h11111, 0, 0, 1, 1, 1));

      // R11: both requests in the same idle cycle
      lat = 1;
      wb_seen = 0;
      exp_q.push_back(model(va_of(8'h01, 11'h007, 13'h0), 0, 1'b1, 1'b1, 1'b0));
      tag_q.push_back("R11");
      exp_q.push_back(model(va_of(8'h01, 11'h005, 13'h44), 0, 1'b0, 1'b0, 1'b0));
      tag_q.push_back("R11");
      wb_vaddr = va_of(8'h01, 11'h007, 13'h0); wb_accessed = 1; wb_dirty = 0; wb_valid = 1;
      miss_vaddr = va_of(8'h01, 11'h005, 13'h44); miss_fetch = 0; miss_valid = 1;
      #1;
      check(wb_accept && !miss_accept, "R11", "write-back taken alone",
            {wb_accept, miss_accept}, 2'b10);
      @(posedge clk); #1;
      wb_valid = 0;
      while (!miss_accept) begin @(negedge clk); #1; end
      check(wb_seen, "R11", "miss accepted after wb_done", wb_seen, 1);
      @(posedge clk); #1;
      miss_valid = 0;
      wait_idle();

      // R12, R8, R7 end-of-run checks
      check(busy_accepts == 0, "R12", "accepts while busy", busy_accepts, 0);
      check(hold_err == 0, "R8", "request changed before ack", hold_err, 0);
      check(exp_q.size() == 0, "R7", "pending completions", exp_q.size(), 0);

      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule